// File: doc/BRIEF.md
# Antenna Diversity Comparison Sequencer

This block chooses the stronger of two antennas. It measures received signal strength in two timed windows and keeps the result. The strength arrives as one unsigned digital sample per clock. While an enable window is high, the block steps through a fixed clock-count schedule:

- a settle phase that clears the peak trackers;
- a first acquisition, in which the peak of the first antenna is tracked;
- a gap, in which the first peak is held and the second tracker is cleared, and in which a one-clock request asks external logic to switch antennas;
- a second acquisition, in which the peak of the second antenna is tracked.

A measurement-control output is high during the two acquisitions. It stays high after the second acquisition until the window ends. When the window drops, the block compares the two peaks and latches the winner on a best-antenna output. It lowers measurement-control one clock later and returns to idle. If the window ends early, the block compares whatever peaks it has gathered so far.

Top module: `diversity_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `best_o`, `meas_o` and `swap_o` are all 0.
- R2: Let edge 0 be the first rising edge at which idle sees `win_i` high. `meas_o` stays 0 after edges 0 to 3 and becomes 1 after edge 4.
- R3: `meas_o` is 1 after edges 4 to 11. The first peak is the maximum of `sample_i` sampled at edges 5 to 12, starting from 0.
- R4: `meas_o` is 0 after edges 12 to 15. `swap_o` is 1 for exactly one cycle, after edge 12, and is 0 at all other times.
- R5: `meas_o` is 1 from edge 16 until the window ends. The second peak is the maximum of `sample_i` sampled at edges 17 to 24, starting from 0. Later samples are ignored.
- R6: At the first rising edge that sees `win_i` low during a sequence, `best_o` is loaded with 1 if the second peak is strictly greater than the first, and with 0 otherwise (a tie gives 0). `best_o` does not change at any other time.
- R7: At that falling-window edge `meas_o` keeps its value. One edge later `meas_o` is 0 and the block is idle.
- R8: If the window falls before edge 25, the comparison uses only the samples gathered up to the previous edge. A peak that has not started acquiring counts as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_i | input | 1 | Comparison window enable |
| sample_i | input | W | Signal strength sample, unsigned |
| meas_o | output | 1 | Measurement control, high while peaks are acquired |
| swap_o | output | 1 | One-clock request to switch to the second antenna |
| best_o | output | 1 | Latched best antenna: 0 = first, 1 = second |

## Verification
The bench targets windows that end at each phase boundary. Examples are a window that ends during the settle phase, at the last first-acquisition edge, or partway through the second acquisition. A design that let the falling edge's sample into a peak, or that kept tracking past the eighth acquisition edge, would pick the wrong antenna in these windows. Equal peaks test the tie rule: a design that used a greater-or-equal compare would raise `best_o`. Checking `meas_o` cycle by cycle around the window end catches a design that powers down at once instead of one clock later.

// File: rtl/diversity_seq.sv
module diversity_seq #(
  parameter int W       = 8,
  parameter int CLR_CYC = 4,
  parameter int ACQ_CYC = 8,
  parameter int GAP_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_i,
  input  logic [W-1:0] sample_i,
  output logic         meas_o,
  output logic         swap_o,
  output logic         best_o
);
  localparam int MAXC = (ACQ_CYC > CLR_CYC) ? ((ACQ_CYC > GAP_CYC) ? ACQ_CYC : GAP_CYC)
                                            : ((CLR_CYC > GAP_CYC) ? CLR_CYC : GAP_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ACQ1, S_GAP, S_ACQ2, S_DONE, S_PDN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  pk_a, pk_b;

  wire clr_end = cnt == CW'(CLR_CYC - 1);
  wire acq_end = cnt == CW'(ACQ_CYC - 1);
  wire gap_end = cnt == CW'(GAP_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pk_a   <= '0;
      pk_b   <= '0;
      meas_o <= 1'b0;
      swap_o <= 1'b0;
      best_o <= 1'b0;
    end else begin
      swap_o <= 1'b0;
      case (st)
        S_IDLE: if (win_i) begin
          st   <= S_CLR;
          cnt  <= '0;
          pk_a <= '0;
          pk_b <= '0;
        end
        S_PDN: begin
          meas_o <= 1'b0;
          st     <= S_IDLE;
        end
        default: if (!win_i) begin
          best_o <= pk_b > pk_a;
          st     <= S_PDN;
        end else begin
          case (st)
            S_CLR: if (clr_end) begin
              st <= S_ACQ1; cnt <= '0; meas_o <= 1'b1;
            end else cnt <= cnt + 1'b1;
            S_ACQ1: begin
              if (sample_i > pk_a) pk_a <= sample_i;
              if (acq_end) begin
                st <= S_GAP; cnt <= '0; meas_o <= 1'b0; swap_o <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
            S_GAP: begin
              pk_b <= '0;
              if (gap_end) begin
                st <= S_ACQ2; cnt <= '0; meas_o <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
            S_ACQ2: begin
              if (sample_i > pk_b) pk_b <= sample_i;
              if (acq_end) st <= S_DONE;
              else cnt <= cnt + 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  // R4
  swap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> !swap_o);

  // R7
  meas_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PDN) |=> !meas_o);

  // R6
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(best_o) |-> (st == S_PDN));

  // R2
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLR || st == S_IDLE) |-> !meas_o && !swap_o);

  // R3
  peak_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACQ1 && win_i) |=> pk_a >= $past(sample_i));
endmodule

// File: tb/tb_diversity_seq.sv
`timescale 1ns/1ps
module tb_diversity_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic       meas_o, swap_o, best_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] s [64];
  logic prev_best = 1'b0;

  always #2.5 clk = ~clk;

  diversity_seq dut (.clk(clk), .rst_n(rst_n), .win_i(win_i), .sample_i(sample_i),
                     .meas_o(meas_o), .swap_o(swap_o), .best_o(best_o));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic meas_at(int n);
    return (n >= 4 && n <= 11) || (n >= 16);
  endfunction

  function automatic logic exp_best(int len);
    logic [7:0] a = 0, b = 0;
    for (int i = 5; i <= 12 && i < len; i++) if (s[i] > a) a = s[i];
    for (int i = 17; i <= 24 && i < len; i++) if (s[i] > b) b = s[i];
    return b > a;
  endfunction

  function automatic string meas_tag(int n);
    if (n < 4) return "R2";
    if (n < 12) return "R3";
    if (n < 16) return "R4";
    return "R5";
  endfunction

  task automatic run_window(input int len);
    logic eb = exp_best(len);
    string btag = (len < 25) ? "R8" : "R6";
    @(negedge clk);
    win_i = 1'b1;
    sample_i = s[0];
    for (int n = 0; n <= len + 1; n++) begin
      @(negedge clk);
      if (n < len) begin
        chk(meas_o, meas_at(n), meas_tag(n));
        chk(swap_o, n == 12, "R4");
        chk(best_o, prev_best, "R6");
      end else if (n == len) begin
        chk(meas_o, meas_at(len - 1), "R7");
        chk(swap_o, 1'b0, "R4");
        chk(best_o, eb, btag);
      end else begin
        chk(meas_o, 1'b0, "R7");
        chk(best_o, eb, btag);
      end
      win_i = (n + 1 < len);
      sample_i = (n + 1 < 64) ? s[n + 1] : 8'h00;
    end
    prev_best = eb;
    repeat (3) begin
      @(negedge clk);
      chk(meas_o, 1'b0, "R7");
      chk(best_o, prev_best, "R6");
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 64; i++) s[i] = v;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    #1;
    checks++; if (meas_o !== 0 || swap_o !== 0 || best_o !== 0) begin errors++;
      $display("FAIL R1: actual %0b%0b%0b expected 000", meas_o, swap_o, best_o); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(meas_o, 1'b0, "R1");
    chk(swap_o, 1'b0, "R1");
    chk(best_o, 1'b0, "R1");

    fill(8'd50); run_window(30);                          // R6 tie
    fill(8'd10); s[20] = 8'd11; run_window(30);           // R6 second wins
    fill(8'd10); s[5] = 8'd200; run_window(30);           // R6 first wins
    fill(8'd10); s[24] = 8'd90; s[25] = 8'd0; run_window(28); // R5 last edge
    fill(8'd10); s[25] = 8'd255; run_window(40);          // R5 late ignored
    fill(8'd10); s[4] = 8'd0; s[12] = 8'd0; s[17] = 8'd3; run_window(30); // R3 window
    fill(8'd0); s[3] = 8'd99; run_window(2);              // R8 early
    fill(8'd5); run_window(10);                           // R8 in first acquire
    fill(8'd5); s[12] = 8'd0; run_window(12);             // R8 last acquire edge
    fill(8'd5); s[18] = 8'd6; run_window(20);             // R8 partial second
    fill(8'd5); s[22] = 8'd60; run_window(20);            // R8 excluded sample
    fill(8'd5); s[16] = 8'd60; run_window(17);            // R8 gap sample ignored

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 64; i++) s[i] = 8'($urandom_range(0, 12));
      run_window($urandom_range(1, 40));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule